// File: doc/BRIEF.md
# Third-order noise-shaping delta-sigma modulator

This block is a fixed-point digital delta-sigma modulator. On each clock where the enable strobe is high, it takes one signed input sample and turns it into a short level code. The code uses 2, 4 or 8 evenly spaced midrise levels, chosen by a resolution select. The block also outputs the signed fixed-point value of that level.

The quantisation noise is shaped by a third-order noise transfer function (NTF). The NTF has three zeros at DC. Its poles are moved toward z=1, which keeps the peak noise gain near Fs/2 to about 1.71. Over many samples, the mean output tracks a DC input that lies inside the stable range.

The loop uses an error-feedback structure. The quantiser input is the sample, plus an optional dither term scaled by a gain, plus a recursive filter of past quantisation errors. That filter realises NTF−1. Every stored error and filter state clips at ±8 rather than wrapping. Downstream decimation is the user's job.

Top module: `dsm3_shaper`

## Requirements
- R1: While `rst` is high at a clock edge, all error and filter state registers are cleared, and both `code` and `level` read 0 until the first enabled sample.
- R2: State and outputs change only on clock edges where `en` is high. A sample presented with `en` high appears on `code` and `level` after that edge. With `en` low, nothing moves, whatever the inputs do.
- R3: Values are signed fixed point with F=16 fractional bits, so 1.0 is 65536. `qsel`=0 selects 1-bit mode: a quantiser input v ≥ 0 gives code 1 and level +65536; otherwise the block gives code 0 and level −65536.
- R4: `qsel`=1 selects 2-bit mode. The thresholds are −2/3, 0 and +2/3, each rounded to the nearest LSB. The code is the number of thresholds at or below v. Codes 0..3 map to levels −1, −1/3, +1/3 and +1, also rounded.
- R5: `qsel`=2 or 3 selects 3-bit mode. The thresholds are (2j−6)/7 for j=0..6, and the levels are (2k−7)/7 for code k=0..7. Both are rounded, and the code is the count of thresholds at or below v.
- R6: The loop is bit-exact to this recurrence. v = din + dither + w, with w = (b1·e1+b2·e2+b3·e3 − a1·w1−a2·w2−a3·w3) >>> 16 (floor). The new error is e = level − v. The coefficients are a1..a3 from (z−0.5903)(z²−1.363z+0.5792) and b = (−3−a1, 3−a2, −1−a3), rounded to 16 fractional bits.
- R7: Each stored error and filter sample saturates at ±8.0 (±524288).
- R8: The dither term is (`dith` × `dgain`) >>> 4 (floor), so `dgain` carries 4 fractional bits. With `dgain`=0, `dith` has no effect on the output.
- R9: For an undithered DC input inside the stable range, the mean of `level` over 8192 samples is within 1e-3 of the input.
- R10: An emitted code is always below the level count of the mode in force when it was produced. The level is positive exactly when the code lies in the upper half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Sample strobe; the loop advances when high |
| din | input | 18 | Signed input sample, 16 fractional bits |
| dith | input | 16 | Signed dither word, 16 fractional bits |
| dgain | input | 8 | Unsigned dither gain, 4 fractional bits |
| qsel | input | 2 | Resolution: 0 = 1 bit, 1 = 2 bits, 2/3 = 3 bits |
| code | output | 3 | Quantised level index, 0 = most negative |
| level | output | 18 | Signed value of the emitted level, 16 fractional bits |

## Verification
Four properties are checked on every cycle:
- the saturation bound on the stored error and filter samples;
- the freeze of outputs and state while `en` is low;
- the reset values of the outputs;
- the consistency between the code range, the level sign and the active mode.

The bench's scenarios cover the rest. These are the bit-exact recurrence against an independent model, the exact threshold placement in each mode, and the fact that dither is ignored at zero gain. The scenarios also cover DC tracking of the long-run mean and clipping behaviour under an overloaded input.

// File: rtl/dsm3_shaper.sv
module dsm3_shaper #(
  parameter int F    = 16,
  parameter int GW   = 8,
  parameter int GF   = 4,
  parameter int SATI = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic signed [F+1:0] din,
  input  logic signed [F-1:0] dith,
  input  logic [GW-1:0]       dgain,
  input  logic [1:0]          qsel,
  output logic [2:0]          code,
  output logic signed [F+1:0] level
);
  localparam int SW  = F + $clog2(SATI) + 2;
  localparam int ACC = 48;
  typedef logic signed [ACC-1:0] acc_t;

  localparam real ONE = real'(64'd1 << F);
  localparam real PR  = 0.5903;
  localparam real QB  = 1.363;
  localparam real QC  = 0.5792;
  localparam real RA1 = -(QB + PR);
  localparam real RA2 = QC + PR * QB;
  localparam real RA3 = -PR * QC;

  function automatic acc_t rnd(real x);
    if (x >= 0.0) return acc_t'($rtoi(x + 0.5));
    return -acc_t'($rtoi(-x + 0.5));
  endfunction

  function automatic acc_t thr(int b, int j);
    int n;
    n = (1 << b) - 1;
    if (j >= n) return acc_t'(64'sd1 <<< 40);
    return rnd(real'(2 * j - (n - 1)) * ONE / real'(n));
  endfunction

  function automatic acc_t lvl(int b, int k);
    int n;
    n = (1 << b) - 1;
    if (k > n) return '0;
    return rnd(real'(2 * k - n) * ONE / real'(n));
  endfunction

  localparam acc_t SATV = acc_t'(SATI) <<< F;
  localparam acc_t KA1 = rnd(RA1 * ONE);
  localparam acc_t KA2 = rnd(RA2 * ONE);
  localparam acc_t KA3 = rnd(RA3 * ONE);
  localparam acc_t KB1 = rnd((-3.0 - RA1) * ONE);
  localparam acc_t KB2 = rnd((3.0 - RA2) * ONE);
  localparam acc_t KB3 = rnd((-1.0 - RA3) * ONE);

  localparam acc_t THR [3][7] = '{
    '{thr(1,0), thr(1,1), thr(1,2), thr(1,3), thr(1,4), thr(1,5), thr(1,6)},
    '{thr(2,0), thr(2,1), thr(2,2), thr(2,3), thr(2,4), thr(2,5), thr(2,6)},
    '{thr(3,0), thr(3,1), thr(3,2), thr(3,3), thr(3,4), thr(3,5), thr(3,6)}
  };
  localparam acc_t LVL [3][8] = '{
    '{lvl(1,0), lvl(1,1), lvl(1,2), lvl(1,3), lvl(1,4), lvl(1,5), lvl(1,6), lvl(1,7)},
    '{lvl(2,0), lvl(2,1), lvl(2,2), lvl(2,3), lvl(2,4), lvl(2,5), lvl(2,6), lvl(2,7)},
    '{lvl(3,0), lvl(3,1), lvl(3,2), lvl(3,3), lvl(3,4), lvl(3,5), lvl(3,6), lvl(3,7)}
  };

  function automatic logic signed [SW-1:0] clip(acc_t x);
    if (x > SATV)  return SW'(SATV);
    if (x < -SATV) return SW'(-SATV);
    return x[SW-1:0];
  endfunction

  logic signed [SW-1:0] e1, e2, e3, w1, w2, w3;
  acc_t wsum, wnow, dsc, v, lv, err;
  logic [1:0] msel;
  logic [2:0] cn;

  assign msel = (qsel == 2'd3) ? 2'd2 : qsel;
  assign wsum = KB1 * acc_t'(e1) + KB2 * acc_t'(e2) + KB3 * acc_t'(e3)
              - KA1 * acc_t'(w1) - KA2 * acc_t'(w2) - KA3 * acc_t'(w3);
  assign wnow = wsum >>> F;
  assign dsc  = (acc_t'(dith) * acc_t'({1'b0, dgain})) >>> GF;
  assign v    = acc_t'(din) + dsc + wnow;

  always_comb begin
    cn = 3'd0;
    for (int j = 0; j < 7; j++)
      if (v >= THR[msel][j]) cn = cn + 3'd1;
    lv = LVL[msel][cn];
  end

  assign err = lv - v;

  always_ff @(posedge clk) begin
    if (rst) begin
      e1 <= '0; e2 <= '0; e3 <= '0;
      w1 <= '0; w2 <= '0; w3 <= '0;
      code  <= '0;
      level <= '0;
    end else if (en) begin
      e1 <= clip(err); e2 <= e1; e3 <= e2;
      w1 <= clip(wnow); w2 <= w1; w3 <= w2;
      code  <= cn;
      level <= lv[F+1:0];
    end
  end

  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (code == 3'd0 && level == '0 && e1 == '0 && w1 == '0)); // R1
  AST_IDLE_FREEZE: assert property (@(posedge clk) disable iff (rst) !en |=> ($stable(code) && $stable(level) && $stable(e1) && $stable(w1))); // R2
  AST_STATE_CLIP: assert property (@(posedge clk) disable iff (rst) (acc_t'(e1) <= SATV && acc_t'(e1) >= -SATV && acc_t'(w1) <= SATV && acc_t'(w1) >= -SATV)); // R7
  AST_CODE_RANGE: assert property (@(posedge clk) disable iff (rst) en |=> (($past(qsel) == 2'd0) ? (code < 3'd2) : ($past(qsel) == 2'd1) ? (code < 3'd4) : 1'b1)); // R10
  AST_LEVEL_SIGN: assert property (@(posedge clk) disable iff (rst) en |=> ((level > 0) == (code >= (($past(qsel) == 2'd0) ? 3'd1 : ($past(qsel) == 2'd1) ? 3'd2 : 3'd4)))); // R10
endmodule

// File: tb/test_dsm3_shaper.sv
module test_dsm3_shaper;
  localparam int F = 16;
  logic clk = 0, rst = 1, en = 0;
  logic signed [F+1:0] din = '0;
  logic signed [F-1:0] dith = '0;
  logic [7:0] dgain = '0;
  logic [1:0] qsel = '0;
  logic [2:0] code;
  logic signed [F+1:0] level;

  dsm3_shaper i_dsm3_shaper (.clk(clk), .rst(rst), .en(en), .din(din), .dith(dith),
    .dgain(dgain), .qsel(qsel), .code(code), .level(level));

  always #2 clk = ~clk;

  int total = 0, bad = 0;
  longint ka1, ka2, ka3, kb1, kb2, kb3;
  longint me1, me2, me3, mw1, mw2, mw3;
  longint xcode, xlev;
  logic [15:0] lfsr = 16'hACE1;

  function automatic longint rq(real x);
    if (x >= 0.0) return longint'($rtoi(x + 0.5));
    return -longint'($rtoi(-x + 0.5));
  endfunction

  function automatic longint sat8(longint x);
    if (x > 524288) return 524288;
    if (x < -524288) return -524288;
    return x;
  endfunction

  task automatic chk(bit ok, string tag, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model(longint u, longint d, longint g, int q);
    longint w, v, e;
    int n;
    n = (q == 0) ? 1 : (q == 1) ? 3 : 7;
    w = (kb1*me1 + kb2*me2 + kb3*me3 - ka1*mw1 - ka2*mw2 - ka3*mw3) >>> F;
    v = u + ((d * g) >>> 4) + w;
    xcode = 0;
    for (int j = 0; j < n; j++)
      if (v >= rq(real'(2*j - (n-1)) * 65536.0 / real'(n))) xcode++;
    xlev = rq(real'(2*xcode - n) * 65536.0 / real'(n));
    e = xlev - v;
    me3 = me2; me2 = me1; me1 = sat8(e);
    mw3 = mw2; mw2 = mw1; mw1 = sat8(w);
  endtask

  task automatic do_reset();
    en = 0; rst = 1;
    @(negedge clk); @(negedge clk);
    rst = 0;
    me1 = 0; me2 = 0; me3 = 0; mw1 = 0; mw2 = 0; mw3 = 0;
    chk(code == 0, "R1 reset code", code, 0);
    chk(level == 0, "R1 reset level", level, 0);
  endtask

  // drive one enabled sample at a negedge, compare at the following negedge
  task automatic step(longint u, longint d, longint g, int q, longint md, string tag);
    din = u[F+1:0]; dith = d[F-1:0]; dgain = g[7:0]; qsel = q[1:0]; en = 1;
    model(u, md, g, q);
    @(negedge clk);
    chk(code == xcode[2:0], tag, code, xcode);
    chk(level == xlev, tag, level, xlev);
  endtask

  function automatic longint nextd();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return longint'($signed(lfsr));
  endfunction

  // mode, dc input (Q16), dither gain (Q4.4), check mean
  localparam int NV = 6;
  localparam longint VEC [NV][4] = '{
    '{0,  16384, 0, 1},
    '{0, -32768, 0, 1},
    '{1,  39322, 0, 1},
    '{1, -52429, 0, 1},
    '{2,  58982, 0, 1},
    '{2, -19661, 4, 0}
  };

  initial begin
    #(4 * 200000);
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    ka1 = rq(-(1.363 + 0.5903) * 65536.0);
    ka2 = rq((0.5792 + 0.5903 * 1.363) * 65536.0);
    ka3 = rq(-(0.5903 * 0.5792) * 65536.0);
    kb1 = rq((-3.0 + (1.363 + 0.5903)) * 65536.0);
    kb2 = rq((3.0 - (0.5792 + 0.5903 * 1.363)) * 65536.0);
    kb3 = rq((-1.0 + 0.5903 * 0.5792) * 65536.0);
    @(negedge clk);
    do_reset();

    // R3/R4/R5 thresholds: right after reset v equals din
    step(0, 0, 0, 0, 0, "R3 v=0 gives top code");
    do_reset(); step(-1, 0, 0, 0, 0, "R3 v=-1lsb gives code 0");
    do_reset(); step(-43691, 0, 0, 1, 0, "R4 at -2/3 threshold");
    chk(code == 1, "R4 code at -2/3", code, 1);
    do_reset(); step(-43692, 0, 0, 1, 0, "R4 below -2/3 threshold");
    chk(code == 0, "R4 code below -2/3", code, 0);
    do_reset(); step(43691, 0, 0, 1, 0, "R4 at +2/3 threshold");
    chk(level == 65536, "R4 top level", level, 65536);
    do_reset(); step(18725, 0, 0, 2, 0, "R5 at 2/7 threshold");
    chk(code == 5, "R5 code at 2/7", code, 5);
    do_reset(); step(18724, 0, 0, 3, 0, "R5 below 2/7, qsel=3");
    chk(code == 4 && level == 9362, "R5 level 1/7", level, 9362);

    // R6/R9 main table
    for (int i = 0; i < NV; i++) begin
      real sum, mean;
      do_reset();
      sum = 0.0;
      for (int s = 0; s < 64; s++) begin
        longint d = nextd();
        step(VEC[i][1], d, VEC[i][2], int'(VEC[i][0]), d, "R6 warmup");
      end
      for (int s = 0; s < 8192; s++) begin
        longint d = nextd();
        step(VEC[i][1], d, VEC[i][2], int'(VEC[i][0]), d, "R6 loop match");
        sum += real'(level);
      end
      mean = sum / 8192.0 / 65536.0;
      if (VEC[i][3] != 0)
        chk((mean - real'(VEC[i][1]) / 65536.0) < 1e-3 && (real'(VEC[i][1]) / 65536.0 - mean) < 1e-3,
            "R9 dc mean (x1e6)", longint'(mean * 1e6), longint'(real'(VEC[i][1]) / 65536.0 * 1e6));
    end

    // R2 enable low: outputs and state frozen
    do_reset();
    for (int s = 0; s < 20; s++) step(30000, 0, 0, 1, 0, "R2 prefill");
    begin
      logic [2:0] hc; logic signed [F+1:0] hl;
      hc = code; hl = level;
      en = 0; din = -100000; qsel = 2;
      for (int s = 0; s < 5; s++) @(negedge clk);
      chk(code == hc, "R2 code held", code, hc);
      chk(level == hl, "R2 level held", level, hl);
    end
    for (int s = 0; s < 20; s++) step(30000, 0, 0, 1, 0, "R2 resume state intact");

    // R8 zero gain ignores dither
    do_reset();
    for (int s = 0; s < 300; s++) step(12000, nextd(), 0, 2, 0, "R8 zero gain");

    // R7 overload clips states
    do_reset();
    for (int s = 0; s < 300; s++) step(124518, 0, 0, 0, 0, "R7 overload clip");

    en = 0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule